// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns a set of undervoltage flags and a manual reset request into one active-low system reset. The flags are digital and come from external comparators on the monitored rails, one of them usually from a divider on an extra rail. The manual request is active low and comes from a pushbutton or from other logic. Reset goes low as soon as any fault is seen. It stays low for a selected timeout after the last fault has gone away. If a fault comes back before the timeout ends, the timeout starts again from zero.

Time is counted in ticks from a free-running prescaler. The default tick is 50 µs at a 250 MHz clock. A static 3-bit option code selects one of six timeout lengths. All inputs pass through two-flop synchronizers. The manual request also passes through a glitch filter, so it needs no external debounce. A one-cycle event pulse marks each entry into reset, so that a watchdog can restart its initial period.

Top module: `supply_reset_seq`

## Requirements
- R1: A high level on any bit of `uv_flag_i` for at least one cycle drives `sys_rst_n_o` low on the third rising clock edge after the input changes. The delay is two synchronizer stages plus the state register.
- R2: If `mr_n_i` stays low for at least `MR_FILT_CYCLES` consecutive cycles, `sys_rst_n_o` goes low on edge `MR_FILT_CYCLES`+3 after the input falls.
- R3: A low pulse on `mr_n_i` shorter than `MR_FILT_CYCLES` cycles is ignored. `sys_rst_n_o` stays high and `rst_event_o` does not pulse.
- R4: After the last fault clears, reset stays low for the selected number of ticks. One tick lasts `PRESCALE` cycles. With `PRESCALE`=1 the output rises at edge N+2 after a flag clears, or at edge N+3 after `mr_n_i` returns high, where N is the tick count.
- R5: If a fault returns before the timeout ends, the count restarts from zero. The release is then measured from the last clearing.
- R6: Tick counts for each `tmo_sel_i` value: 1→33, 2→264, 3→4200, 5→8400, 6→16800, 4→33600. In 50 µs ticks these are 1.65, 13.2, 210, 420, 840 and 1680 ms. The unused codes 0 and 7 select 33600.
- R7: `sys_rst_n_o` is low while `rst_n` is low. After `rst_n` rises with no fault present, it rises on edge N (with `PRESCALE`=1).
- R8: `rst_event_o` pulses high for exactly one cycle, in the same cycle that `sys_rst_n_o` goes from high to low. It does not pulse on local reset or on a new fault while reset is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Local asynchronous power-on reset, active low |
| uv_flag_i | input | NUM_FLAGS | Asynchronous undervoltage flags, 1 = rail below threshold |
| mr_n_i | input | 1 | Asynchronous manual reset request, active low |
| tmo_sel_i | input | 3 | Static timeout option code |
| sys_rst_n_o | output | 1 | System reset, active low |
| rst_event_o | output | 1 | One-cycle pulse on each entry into reset |

## Verification
The bench builds the block with `PRESCALE`=1, so every clock is a tick and the release edge can be predicted exactly, to the cycle. It uses `MR_FILT_CYCLES`=4, which puts the accept/reject boundary of the filter at pulses of 3 and 4 cycles. With these values the short codes allow many random flag, manual-reset and retrigger trials. Each of the long codes, including the unused ones, is still run once within the cycle budget.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam int unsigned TMO_UNITS_MAX = 33600;
  localparam int TMO_CNT_W = $clog2(TMO_UNITS_MAX + 1);

  typedef logic [2:0] tmo_code_t;

  // Timeout length in prescaler ticks; unused codes give the longest.
  function automatic logic [TMO_CNT_W-1:0] tmo_units(input tmo_code_t code);
    logic [TMO_CNT_W-1:0] n;
    case (code)
      3'd1:    n = TMO_CNT_W'(33);
      3'd2:    n = TMO_CNT_W'(264);
      3'd3:    n = TMO_CNT_W'(4200);
      3'd5:    n = TMO_CNT_W'(8400);
      3'd6:    n = TMO_CNT_W'(16800);
      default: n = TMO_CNT_W'(TMO_UNITS_MAX);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/supv_tick_gen.sv
module supv_tick_gen #(
  parameter int PRESCALE = 12500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = $clog2(PRESCALE + 1);

  generate
    if (PRESCALE <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [PW-1:0] pcnt_q;
      assign tick_o = (pcnt_q == PW'(PRESCALE - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pcnt_q <= '0;
        else if (tick_o) pcnt_q <= '0;
        else             pcnt_q <= pcnt_q + PW'(1);
      end
      // R4
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/supv_mr_filter.sv
module supv_mr_filter #(
  parameter int FILT = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_low_i,
  output logic mr_act_o
);
  localparam int FW = $clog2(FILT + 1);

  logic [FW-1:0] low_cnt_q;
  logic          qualify_w;

  assign qualify_w = mr_low_i && (low_cnt_q == FW'(FILT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      mr_act_o  <= 1'b0;
    end else if (!mr_low_i) begin
      low_cnt_q <= '0;
      mr_act_o  <= 1'b0;
    end else if (qualify_w) begin
      mr_act_o  <= 1'b1;
    end else begin
      low_cnt_q <= low_cnt_q + FW'(1);
    end
  end

  // R3
  mr_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mr_act_o) |-> $past(mr_low_i));
  // R2
  mr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mr_low_i |=> !mr_act_o);
endmodule

// File: rtl/supv_timeout.sv
module supv_timeout #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             asserted_o,
  output logic             event_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             last_tick_w;
  logic             release_w;

  assign last_tick_w = tick_i && (cnt_q == limit_i - CNT_W'(1));
  assign release_w   = asserted_o && !fault_i && last_tick_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asserted_o <= 1'b1;
      cnt_q      <= '0;
      event_o    <= 1'b0;
    end else begin
      event_o <= fault_i && !asserted_o;
      if (fault_i) begin
        asserted_o <= 1'b1;
        cnt_q      <= '0;
      end else if (release_w) begin
        asserted_o <= 1'b0;
        cnt_q      <= '0;
      end else if (asserted_o && tick_i) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R1
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> asserted_o);
  // R5
  release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asserted_o) |-> !$past(fault_i));
  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit_i);
  // R8
  event_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> (asserted_o && !$past(asserted_o)));
  // R8
  event_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |=> !event_o);
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
  parameter int NUM_FLAGS      = 3,
  parameter int PRESCALE       = 12500,
  parameter int MR_FILT_CYCLES = 250
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] uv_flag_i,
  input  logic                 mr_n_i,
  input  logic [2:0]           tmo_sel_i,
  output logic                 sys_rst_n_o,
  output logic                 rst_event_o
);
  localparam int CNT_W = supv_pkg::TMO_CNT_W;

  logic [NUM_FLAGS-1:0] flag_s;
  logic                 mr_n_s;
  logic                 mr_act;
  logic                 tick;
  logic                 fault;
  logic                 asserted;
  logic [CNT_W-1:0]     limit;

  supv_sync #(.W(NUM_FLAGS), .RST_VAL('0)) u_flag_sync (
    .clk(clk), .rst_n(rst_n), .d_i(uv_flag_i), .q_o(flag_s));

  supv_sync #(.W(1), .RST_VAL(1'b1)) u_mr_sync (
    .clk(clk), .rst_n(rst_n), .d_i(mr_n_i), .q_o(mr_n_s));

  supv_mr_filter #(.FILT(MR_FILT_CYCLES)) u_mr_filt (
    .clk(clk), .rst_n(rst_n), .mr_low_i(!mr_n_s), .mr_act_o(mr_act));

  supv_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick));

  assign fault = (|flag_s) || mr_act;
  assign limit = supv_pkg::tmo_units(tmo_sel_i);

  supv_timeout #(.CNT_W(CNT_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .fault_i(fault), .tick_i(tick),
    .limit_i(limit), .asserted_o(asserted), .event_o(rst_event_o));

  assign sys_rst_n_o = !asserted;

  // R7
  always @(posedge clk) begin
    if (!rst_n) por_low_chk: assert (!sys_rst_n_o);
  end
endmodule

// File: tb/supply_reset_seq_test.sv
module supply_reset_seq_test;
  localparam int NF = 3;
  localparam int PS = 1;
  localparam int MF = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [NF-1:0] uv = '0;
  logic          mr_n = 1'b1;
  logic [2:0]    sel = 3'd1;
  logic          sys_rst_n;
  logic          evt;

  int checks = 0;
  int errors = 0;
  int evt_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  supply_reset_seq #(.NUM_FLAGS(NF), .PRESCALE(PS), .MR_FILT_CYCLES(MF)) uut (
    .clk(clk), .rst_n(rst_n), .uv_flag_i(uv), .mr_n_i(mr_n),
    .tmo_sel_i(sel), .sys_rst_n_o(sys_rst_n), .rst_event_o(evt));

  always @(negedge clk) if (evt) evt_cnt++;

  function automatic int units(input int c);
    if (c == 1) return 33;
    if (c == 2) return 264;
    if (c == 3) return 4200;
    if (c == 5) return 8400;
    if (c == 6) return 16800;
    return 33600;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Drive one or two fault pulses; record edges of output fall and rise.
  task automatic run_seq(input bit is_mr, input int idx, input int l1,
                         input int gap, input int l2, input int code,
                         output int low_at, output int high_at);
    int total;
    bit act;
    @(negedge clk) sel = 3'(code);
    low_at = -1;
    high_at = -1;
    total = l1 + gap + l2;
    for (int e = 0; e < total + units(code) * PS + 12; e++) begin
      @(negedge clk);
      act = (e < l1) || (l2 > 0 && e >= l1 + gap && e < total);
      if (is_mr) mr_n = !act; else uv[idx] = act;
      @(posedge clk); #1;
      if (low_at < 0 && !sys_rst_n) low_at = e + 1;
      if (low_at >= 0 && high_at < 0 && sys_rst_n) begin
        high_at = e + 1;
        break;
      end
    end
    @(negedge clk);
    mr_n = 1'b1;
    uv = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    int lo, hi, e0, k, code, kind, l, g;
    void'($urandom(32'h5EED));
    #1 rst_n = 1'b0;
    // R7: low during reset, then full timeout
    repeat (3) begin
      @(posedge clk); #1;
      chk("R7 low in reset", sys_rst_n, 0);
    end
    @(negedge clk) rst_n = 1'b1;
    k = 0;
    for (int e = 1; e < 200; e++) begin
      @(posedge clk); #1;
      if (sys_rst_n) begin k = e; break; end
    end
    chk("R7 release after power-on", k, units(1));
    chk("R8 no event at power-on", evt_cnt, 0);

    // R1 / R4 flag on each bit
    for (int i = 0; i < NF; i++) begin
      e0 = evt_cnt;
      run_seq(1'b0, i, 5, 0, 0, 1, lo, hi);
      chk("R1 flag assert latency", lo, 3);
      chk("R4 flag release", hi, 5 + units(1) + 2);
      chk("R8 one event", evt_cnt - e0, 1);
    end

    // R3 / R2 filter boundary
    e0 = evt_cnt;
    run_seq(1'b1, 0, MF - 1, 0, 0, 1, lo, hi);
    chk("R3 short MR ignored", lo, -1);
    run_seq(1'b1, 0, 1, 0, 0, 1, lo, hi);
    chk("R3 1-cycle MR ignored", lo, -1);
    chk("R3 no event", evt_cnt - e0, 0);
    run_seq(1'b1, 0, MF, 0, 0, 1, lo, hi);
    chk("R2 MR assert latency", lo, MF + 3);
    chk("R4 MR release", hi, MF + units(1) + 3);

    // R5 retrigger directed, with R8 no second event
    e0 = evt_cnt;
    run_seq(1'b0, 2, 3, units(1) - 2, 4, 1, lo, hi);
    chk("R5 retrigger release", hi, 3 + units(1) - 2 + 4 + units(1) + 2);
    chk("R8 single event on retrigger", evt_cnt - e0, 1);

    // Random mix on short codes
    for (int t = 0; t < 20; t++) begin
      code = ($urandom % 2) + 1;
      kind = $urandom % 3;
      e0 = evt_cnt;
      if (kind == 0) begin
        l = 3 + ($urandom % 8);
        run_seq(1'b0, $urandom % NF, l, 0, 0, code, lo, hi);
        chk("R1 random flag", lo, 3);
        chk("R4 random flag release", hi, l + units(code) + 2);
        chk("R8 random event", evt_cnt - e0, 1);
      end else if (kind == 1) begin
        l = 1 + ($urandom % 8);
        run_seq(1'b1, 0, l, 0, 0, code, lo, hi);
        if (l < MF) begin
          chk("R3 random MR ignored", lo, -1);
          chk("R3 random no event", evt_cnt - e0, 0);
        end else begin
          chk("R2 random MR", lo, MF + 3);
          chk("R4 random MR release", hi, l + units(code) + 3);
        end
      end else begin
        l = 3 + ($urandom % 4);
        g = 1 + ($urandom % (units(code) - 2));
        run_seq(1'b0, $urandom % NF, l, g, 3, code, lo, hi);
        chk("R5 random retrigger", hi, l + g + 3 + units(code) + 2);
        chk("R8 random retrigger event", evt_cnt - e0, 1);
      end
    end

    // R6 long and unused codes
    foreach (code_list[j]) begin
      run_seq(1'b0, 0, 3, 0, 0, code_list[j], lo, hi);
      chk($sformatf("R6 code %0d", code_list[j]), hi, 3 + units(code_list[j]) + 2);
    end

    finish_run();
  end

  int code_list[6] = '{3, 5, 6, 4, 7, 0};
endmodule